// File: doc/BRIEF.md
# Dual-Mode Memory Response Reorder Buffer

This block sits between the stage that issues global memory requests and the stage that writes results back to registers. It keeps track of every load, atomic and store that has been sent to memory. When each one completes, it hands the completion to writeback as a tag. Data payloads are not carried. Only tags, a request kind and handshakes pass through the block.

A mode input, taken only while nothing is outstanding, picks one of two delivery disciplines. In ordered mode, each request gets a slot in a circular ring when it issues. The slot index is the low bits of its sequence number. A returning response only marks that slot finished, and only the oldest slot may retire. In arrival mode, finished loads and atomics go into one FIFO and finished stores into another. The load FIFO is drained first. In both modes, per-class in-flight counters throttle issue. A response whose tag is not outstanding is flagged.

Top module: `mem_resp_reorder`

## Requirements
- R1: After reset no completion is offered (`dlv_valid_o`=0), `orphan_o`=0, and a load issue is accepted.
- R2: In ordered mode (`ooo_mode_i`=0 while idle), completions leave strictly in issue order, whatever order the responses return in. A finished younger request waits behind an unfinished older one. `dlv_store_o` is 1 only for kind 2 (store); kinds 0 (load) and 1 (atomic) give 0.
- R3: In ordered mode, a response for the oldest entry makes `dlv_valid_o` rise in the cycle after the response edge, never in the response cycle itself.
- R4: In arrival mode, loads and atomics leave in the order they returned, as do stores. Whenever a load or atomic is waiting, it goes out before any waiting store.
- R5: A fence (kind 3) is always accepted. It reserves no slot, counts against no limit and produces no completion. A following load is delivered normally.
- R6: Loads plus atomics in flight, and stores in flight, are each limited to QUEUE_CAP. Issue of a class stalls at its limit while the other class may still issue. A delivery frees one place in its class.
- R7: In ordered mode, issue stalls while the new sequence number is RING_DEPTH or more ahead of the oldest outstanding one.
- R8: In ordered mode, while `dlv_ready_i` is low, an offered completion stays offered with the same tag.
- R9: A response whose tag is not outstanding raises `orphan_o` for exactly one cycle, one cycle later, and changes nothing else.
- R10: `ooo_mode_i` takes effect only while no request is outstanding. Changing it with requests in flight leaves the current discipline in force.
- R11: A non-fence issue whose tag is still awaiting its response is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ooo_mode_i | input | 1 | 1 = arrival-order delivery, 0 = program-order delivery |
| iss_valid_i | input | 1 | Issue request present |
| iss_ready_o | output | 1 | Issue request accepted this cycle |
| iss_tag_i | input | TAG_W | Tag of the issued request |
| iss_kind_i | input | 2 | 0 load, 1 atomic, 2 store, 3 fence |
| iss_seq_i | input | SEQ_W | Program-order sequence number |
| rsp_valid_i | input | 1 | A memory response arrives |
| rsp_tag_i | input | TAG_W | Tag of the responding request |
| dlv_valid_o | output | 1 | A completion is offered to writeback |
| dlv_ready_i | input | 1 | Writeback takes the completion |
| dlv_tag_o | output | TAG_W | Tag of the offered completion |
| dlv_store_o | output | 1 | Offered completion is a store |
| orphan_o | output | 1 | Previous cycle carried an unmatched response |

## Verification
The bench goes through every return order of a three-request group in both modes. A design that let a finished younger request pass the oldest one, or that did not give loads priority over an earlier store, would deliver a tag the bench does not expect. It probes the per-class limits and the ring span at their exact edges. A counter that leaked, or a span check off by one, would show up as a wrong ready value. It also checks the one-cycle gap between a response and its delivery, a fence that must leave the ring unblocked, and a mode flip in mid-flight that must not change the delivery order.

// File: rtl/mrb_pkg.sv
package mrb_pkg;
  typedef enum logic [1:0] {
    K_LOAD   = 2'd0,
    K_ATOMIC = 2'd1,
    K_STORE  = 2'd2,
    K_FENCE  = 2'd3
  } req_kind_e;
endpackage

// File: rtl/mrb_arrival_fifo.sv
module mrb_arrival_fifo #(
  parameter int DEPTH = 3,
  parameter int W     = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic         nonempty_o,
  output logic [W-1:0] head_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_q] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= bump(wr_q);
      if (pop_i)  rd_q <= bump(rd_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign nonempty_o = (cnt_q != '0);
  assign head_o     = mem[rd_q];

  // R4: returns are bounded by in-flight limits, so the FIFO never overflows
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i) |-> (cnt_q < CW'(DEPTH)));
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
    pop_i |-> nonempty_o);
endmodule

// File: rtl/mrb_inorder_ring.sv
module mrb_inorder_ring #(
  parameter int DEPTH = 4,
  parameter int SEQ_W = 6,
  parameter int TAG_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     alloc_i,
  input  logic [SEQ_W-1:0]         alloc_seq_i,
  input  logic [TAG_W-1:0]         alloc_tag_i,
  input  logic                     alloc_store_i,
  output logic                     can_alloc_o,
  input  logic                     done_i,
  input  logic [$clog2(DEPTH)-1:0] done_slot_i,
  input  logic                     pop_i,
  output logic                     head_ready_o,
  output logic [TAG_W-1:0]         head_tag_o,
  output logic                     head_store_o
);
  localparam int SLOT_W = $clog2(DEPTH);
  localparam int CW     = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]  vld_q, dn_q;
  logic [TAG_W-1:0]  tag_mem [DEPTH];
  logic [SEQ_W-1:0]  seq_mem [DEPTH];
  logic              st_mem  [DEPTH];
  logic [SLOT_W-1:0] head_q;
  logic [CW-1:0]     cnt_q;

  logic [SLOT_W-1:0] alloc_slot, nxt_slot;
  logic [SEQ_W-1:0]  span;
  logic              ring_empty;

  assign alloc_slot = alloc_seq_i[SLOT_W-1:0];
  assign span       = alloc_seq_i - seq_mem[head_q];
  assign ring_empty = (cnt_q == '0);
  assign can_alloc_o = ring_empty || ((span < SEQ_W'(DEPTH)) && !vld_q[alloc_slot]);

  // next oldest live slot after the head, in circular order
  always_comb begin
    logic [SLOT_W-1:0] idx;
    logic              found;
    found    = 1'b0;
    nxt_slot = head_q;
    for (int k = 1; k < DEPTH; k++) begin
      idx = head_q + SLOT_W'(k);
      if (!found && vld_q[idx]) begin
        found    = 1'b1;
        nxt_slot = idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_i) begin
      tag_mem[alloc_slot] <= alloc_tag_i;
      seq_mem[alloc_slot] <= alloc_seq_i;
      st_mem[alloc_slot]  <= alloc_store_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      dn_q   <= '0;
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (pop_i) vld_q[head_q] <= 1'b0;
      if (alloc_i) begin
        vld_q[alloc_slot] <= 1'b1;
        dn_q[alloc_slot]  <= 1'b0;
      end
      if (done_i) dn_q[done_slot_i] <= 1'b1;
      if (alloc_i && (ring_empty || (pop_i && cnt_q == CW'(1))))
        head_q <= alloc_slot;
      else if (pop_i)
        head_q <= nxt_slot;
      cnt_q <= cnt_q + CW'(alloc_i) - CW'(pop_i);
    end
  end

  assign head_ready_o = vld_q[head_q] && dn_q[head_q];
  assign head_tag_o   = tag_mem[head_q];
  assign head_store_o = st_mem[head_q];

  // R2: a response only finishes a slot that is reserved and still pending
  assert_done_live_R2: assert property (@(posedge clk) disable iff (rst)
    done_i |-> (vld_q[done_slot_i] && !dn_q[done_slot_i]));
  // R2: only a finished oldest slot retires
  assert_pop_ready_R2: assert property (@(posedge clk) disable iff (rst)
    pop_i |-> head_ready_o);
  // R7: a reservation never lands on a live slot
  assert_alloc_free_R7: assert property (@(posedge clk) disable iff (rst)
    (alloc_i && !ring_empty) |-> !vld_q[alloc_slot]);
endmodule

// File: rtl/mem_resp_reorder.sv
module mem_resp_reorder
  import mrb_pkg::*;
#(
  parameter int TAG_W      = 3,
  parameter int SEQ_W      = 6,
  parameter int RING_DEPTH = 4,
  parameter int QUEUE_CAP  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ooo_mode_i,
  input  logic             iss_valid_i,
  output logic             iss_ready_o,
  input  logic [TAG_W-1:0] iss_tag_i,
  input  logic [1:0]       iss_kind_i,
  input  logic [SEQ_W-1:0] iss_seq_i,
  input  logic             rsp_valid_i,
  input  logic [TAG_W-1:0] rsp_tag_i,
  output logic             dlv_valid_o,
  input  logic             dlv_ready_i,
  output logic [TAG_W-1:0] dlv_tag_o,
  output logic             dlv_store_o,
  output logic             orphan_o
);
  localparam int CNT_W  = $clog2(QUEUE_CAP + 1);
  localparam int SLOT_W = $clog2(RING_DEPTH);
  localparam int NTAG   = 1 << TAG_W;

  logic [CNT_W-1:0]  ld_cnt_q, st_cnt_q;
  logic              mode_q, mode_eff, unit_empty;
  logic [NTAG-1:0]   live_q;
  logic              st_tbl   [NTAG];
  logic [SLOT_W-1:0] slot_tbl [NTAG];
  logic              orphan_q;

  logic is_fence, is_st, cap_ok, tag_ok, ring_ok, trk, rsp_ok, dlv_fire;
  logic ring_can, ring_rdy, ring_st;
  logic [TAG_W-1:0] ring_tag, lq_head, sq_head;
  logic lq_ne, sq_ne;

  assign unit_empty = (ld_cnt_q == '0) && (st_cnt_q == '0);
  assign mode_eff   = unit_empty ? ooo_mode_i : mode_q;

  assign is_fence = (iss_kind_i == K_FENCE);
  assign is_st    = (iss_kind_i == K_STORE);
  assign cap_ok   = is_fence || (is_st ? (st_cnt_q < CNT_W'(QUEUE_CAP))
                                       : (ld_cnt_q < CNT_W'(QUEUE_CAP)));
  assign tag_ok   = is_fence || !live_q[iss_tag_i];
  assign ring_ok  = is_fence || mode_eff || ring_can;
  assign iss_ready_o = cap_ok && tag_ok && ring_ok;
  assign trk      = iss_valid_i && iss_ready_o && !is_fence;
  assign rsp_ok   = rsp_valid_i && live_q[rsp_tag_i];

  always_ff @(posedge clk) begin
    if (trk) begin
      st_tbl[iss_tag_i]   <= is_st;
      slot_tbl[iss_tag_i] <= iss_seq_i[SLOT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q   <= '0;
      ld_cnt_q <= '0;
      st_cnt_q <= '0;
      mode_q   <= 1'b0;
      orphan_q <= 1'b0;
    end else begin
      if (rsp_ok) live_q[rsp_tag_i] <= 1'b0;
      if (trk)    live_q[iss_tag_i] <= 1'b1;
      ld_cnt_q <= ld_cnt_q + CNT_W'(trk && !is_st) - CNT_W'(dlv_fire && !dlv_store_o);
      st_cnt_q <= st_cnt_q + CNT_W'(trk && is_st)  - CNT_W'(dlv_fire && dlv_store_o);
      mode_q   <= mode_eff;
      orphan_q <= rsp_valid_i && !live_q[rsp_tag_i];
    end
  end
  assign orphan_o = orphan_q;

  mrb_inorder_ring #(.DEPTH(RING_DEPTH), .SEQ_W(SEQ_W), .TAG_W(TAG_W)) u_ring (
    .clk(clk), .rst(rst),
    .alloc_i(trk && !mode_eff), .alloc_seq_i(iss_seq_i), .alloc_tag_i(iss_tag_i),
    .alloc_store_i(is_st), .can_alloc_o(ring_can),
    .done_i(rsp_ok && !mode_eff), .done_slot_i(slot_tbl[rsp_tag_i]),
    .pop_i(dlv_fire && !mode_eff),
    .head_ready_o(ring_rdy), .head_tag_o(ring_tag), .head_store_o(ring_st)
  );

  mrb_arrival_fifo #(.DEPTH(QUEUE_CAP), .W(TAG_W)) u_ldq (
    .clk(clk), .rst(rst),
    .push_i(rsp_ok && mode_eff && !st_tbl[rsp_tag_i]), .push_data_i(rsp_tag_i),
    .pop_i(dlv_fire && mode_eff && lq_ne),
    .nonempty_o(lq_ne), .head_o(lq_head)
  );

  mrb_arrival_fifo #(.DEPTH(QUEUE_CAP), .W(TAG_W)) u_stq (
    .clk(clk), .rst(rst),
    .push_i(rsp_ok && mode_eff && st_tbl[rsp_tag_i]), .push_data_i(rsp_tag_i),
    .pop_i(dlv_fire && mode_eff && !lq_ne),
    .nonempty_o(sq_ne), .head_o(sq_head)
  );

  always_comb begin
    if (mode_eff) begin
      dlv_valid_o = lq_ne || sq_ne;
      dlv_tag_o   = lq_ne ? lq_head : sq_head;
      dlv_store_o = !lq_ne;
    end else begin
      dlv_valid_o = ring_rdy;
      dlv_tag_o   = ring_tag;
      dlv_store_o = ring_st;
    end
  end
  assign dlv_fire = dlv_valid_o && dlv_ready_i;

  // R6: in-flight counts stay within their limit
  assert_cap_R6: assert property (@(posedge clk) disable iff (rst)
    (ld_cnt_q <= CNT_W'(QUEUE_CAP)) && (st_cnt_q <= CNT_W'(QUEUE_CAP)));
  // R8: an ordered-mode completion is held while writeback stalls
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid_o && !dlv_ready_i && !mode_q && !unit_empty) |=> (dlv_valid_o && $stable(dlv_tag_o)));
  // R5: a fence leaves the in-flight counts untouched
  assert_fence_inert_R5: assert property (@(posedge clk) disable iff (rst)
    (iss_valid_i && is_fence && !dlv_fire) |=> ($stable(ld_cnt_q) && $stable(st_cnt_q)));
  // R10: the discipline cannot change while requests are outstanding
  assert_mode_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !unit_empty |=> $stable(mode_q));
endmodule

// File: tb/mem_resp_reorder_tb.sv
module mem_resp_reorder_tb;
  import mrb_pkg::*;
  localparam int TAG_W = 3;
  localparam int SEQ_W = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic             ooo_mode_i = 1'b0;
  logic             iss_valid_i = 1'b0, iss_ready_o;
  logic [TAG_W-1:0] iss_tag_i = '0;
  logic [1:0]       iss_kind_i = 2'd0;
  logic [SEQ_W-1:0] iss_seq_i = '0;
  logic             rsp_valid_i = 1'b0;
  logic [TAG_W-1:0] rsp_tag_i = '0;
  logic             dlv_valid_o, dlv_ready_i = 1'b0, dlv_store_o, orphan_o;
  logic [TAG_W-1:0] dlv_tag_o;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [SEQ_W-1:0] seq = '0;

  mem_resp_reorder #(.TAG_W(TAG_W), .SEQ_W(SEQ_W), .RING_DEPTH(4), .QUEUE_CAP(3)) u_dut (
    .clk(clk), .rst(rst), .ooo_mode_i(ooo_mode_i),
    .iss_valid_i(iss_valid_i), .iss_ready_o(iss_ready_o), .iss_tag_i(iss_tag_i),
    .iss_kind_i(iss_kind_i), .iss_seq_i(iss_seq_i),
    .rsp_valid_i(rsp_valid_i), .rsp_tag_i(rsp_tag_i),
    .dlv_valid_o(dlv_valid_o), .dlv_ready_i(dlv_ready_i), .dlv_tag_o(dlv_tag_o),
    .dlv_store_o(dlv_store_o), .orphan_o(orphan_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input int tag, input logic [1:0] kind, input string req);
    iss_valid_i = 1'b1; iss_tag_i = TAG_W'(tag); iss_kind_i = kind; iss_seq_i = seq;
    #1 chk(req, int'(iss_ready_o), 1);
    @(posedge clk); #1;
    iss_valid_i = 1'b0;
    seq = seq + 1'b1;
  endtask

  task automatic probe(input int tag, input logic [1:0] kind, input int exp, input string req);
    iss_valid_i = 1'b1; iss_tag_i = TAG_W'(tag); iss_kind_i = kind; iss_seq_i = seq;
    #1 chk(req, int'(iss_ready_o), exp);
    iss_valid_i = 1'b0;
  endtask

  task automatic respond(input int tag);
    rsp_valid_i = 1'b1; rsp_tag_i = TAG_W'(tag);
    @(posedge clk); #1;
    rsp_valid_i = 1'b0;
  endtask

  task automatic take(input int tag, input int st, input string req);
    dlv_ready_i = 1'b1;
    #1;
    chk(req, int'(dlv_valid_o), 1);
    chk(req, int'(dlv_tag_o), tag);
    chk(req, int'(dlv_store_o), st);
    @(posedge clk); #1;
    dlv_ready_i = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state
    chk("R1 valid", int'(dlv_valid_o), 0);
    chk("R1 orphan", int'(orphan_o), 0);
    probe(0, K_LOAD, 1, "R1 ready");

    // R2/R3: ordered mode, every return order of load/atomic/store
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        if (a != b) begin
          int ord[3];
          bit got0;
          ord[0] = a; ord[1] = b; ord[2] = 3 - a - b;
          got0 = 1'b0;
          issue(0, K_LOAD, "R2 issue");
          issue(1, K_ATOMIC, "R2 issue");
          issue(2, K_STORE, "R2 issue");
          for (int i = 0; i < 3; i++) begin
            rsp_valid_i = 1'b1; rsp_tag_i = TAG_W'(ord[i]);
            #1;
            if (ord[i] == 0) chk("R3 same-cycle", int'(dlv_valid_o), 0);
            @(posedge clk); #1;
            rsp_valid_i = 1'b0;
            if (ord[i] == 0) got0 = 1'b1;
            chk("R2 head gating", int'(dlv_valid_o), int'(got0));
          end
          take(0, 0, "R2 order");
          take(1, 0, "R2 order");
          take(2, 1, "R2 order");
          chk("R2 drained", int'(dlv_valid_o), 0);
        end

    // R8: hold while writeback stalls
    issue(3, K_LOAD, "R8 issue");
    respond(3);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk("R8 valid held", int'(dlv_valid_o), 1);
      chk("R8 tag held", int'(dlv_tag_o), 3);
    end
    take(3, 0, "R8 take");

    // R6/R7: ordered-mode limits
    issue(0, K_LOAD, "R6 issue");
    issue(1, K_LOAD, "R6 issue");
    issue(2, K_LOAD, "R6 issue");
    probe(3, K_LOAD, 0, "R6 load cap");
    probe(3, K_STORE, 1, "R6 store free");
    issue(3, K_STORE, "R6 issue");
    probe(4, K_STORE, 0, "R7 ring span");
    respond(3); respond(2); respond(1); respond(0);
    take(0, 0, "R6 drain"); take(1, 0, "R6 drain");
    take(2, 0, "R6 drain"); take(3, 1, "R6 drain");
    probe(4, K_LOAD, 1, "R6 freed");

    // R5: fence
    issue(5, K_FENCE, "R5 fence accept");
    repeat (2) @(posedge clk); #1;
    chk("R5 no completion", int'(dlv_valid_o), 0);
    issue(6, K_LOAD, "R5 after fence");
    respond(6);
    take(6, 0, "R5 after fence");

    // R11: duplicate tag
    issue(2, K_LOAD, "R11 issue");
    probe(2, K_STORE, 0, "R11 dup tag");
    respond(2);
    take(2, 0, "R11 drain");

    // R9: orphan response
    respond(7);
    chk("R9 orphan pulse", int'(orphan_o), 1);
    chk("R9 no completion", int'(dlv_valid_o), 0);
    @(posedge clk); #1;
    chk("R9 orphan clear", int'(orphan_o), 0);
    chk("R9 no completion", int'(dlv_valid_o), 0);

    // R4: arrival mode, every return order
    ooo_mode_i = 1'b1;
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        if (a != b) begin
          int ord[3];
          ord[0] = a; ord[1] = b; ord[2] = 3 - a - b;
          issue(0, K_LOAD, "R4 issue");
          issue(1, K_ATOMIC, "R4 issue");
          issue(2, K_STORE, "R4 issue");
          for (int i = 0; i < 3; i++) begin
            respond(ord[i]);
            chk("R4 offered", int'(dlv_valid_o), 1);
          end
          for (int i = 0; i < 3; i++)
            if (ord[i] != 2) take(ord[i], 0, "R4 load first");
          take(2, 1, "R4 store last");
          chk("R4 drained", int'(dlv_valid_o), 0);
        end

    // R6: arrival-mode store limit
    issue(0, K_STORE, "R6 issue");
    issue(1, K_STORE, "R6 issue");
    issue(2, K_STORE, "R6 issue");
    probe(3, K_STORE, 0, "R6 store cap");
    probe(3, K_LOAD, 1, "R6 load free");
    respond(0); respond(1); respond(2);
    take(0, 1, "R6 drain"); take(1, 1, "R6 drain"); take(2, 1, "R6 drain");
    probe(3, K_STORE, 1, "R6 freed");

    // R10: mode change while busy has no effect
    issue(0, K_LOAD, "R10 issue");
    issue(1, K_STORE, "R10 issue");
    ooo_mode_i = 1'b0;
    respond(1);
    chk("R10 still arrival", int'(dlv_valid_o), 1);
    take(1, 1, "R10 store passes");
    respond(0);
    take(0, 0, "R10 load");
    issue(0, K_LOAD, "R10 now ordered");
    issue(1, K_LOAD, "R10 now ordered");
    respond(1);
    chk("R10 ordered gating", int'(dlv_valid_o), 0);
    respond(0);
    take(0, 0, "R10 ordered");
    take(1, 0, "R10 ordered");

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule